// File: doc/BRIEF.md
# Dual-Core Interrupt Front End with Global Enable

This block sits between the peripherals and each of two processor cores. Peripherals raise requests as single-cycle pulses. Each core keeps its own pending register, so a pulse is never lost and software never has to clear it. Each pending source is then qualified by a per-source enable mask and by a global enable flag for that core. The lowest-numbered qualified source is offered to the core as the interrupt request and its source number.

The instruction decoder of each core sends four strobes:

- enable-interrupts and interrupt-return set the global enable.
- disable-interrupts and service-start clear it.

Because service-start clears the flag, an interrupt service routine is not interrupted again by default, and its return turns interrupts back on. The global enable of each core is reported in bit 14 of that core's 16-bit status word. The two cores share one synchronous active-low reset and are otherwise independent.

Top module: `irq_dual_fe`

## Requirements
- R1: A one-cycle pulse on `irq_pulse` for a source sets that source's pending bit from the next cycle on. The bit stays set until that source is serviced, whatever the mask and global enable are.
- R2: A `svc_stb` with source number `svc_src` clears that source's pending bit from the next cycle on. A pulse for the same source in the same cycle keeps the bit set.
- R3: While `rst_n` is low at a rising edge, both cores are reset. From the next cycle, every pending bit and both global enables are 0, `irq_req` is 0, `irq_src` is 0 and `status_word` is 0.
- R4: An `ei_stb` or an `iret_stb` sets the core's global enable to 1 from the next cycle on.
- R5: A `di_stb` or a `svc_stb` clears the core's global enable to 0 from the next cycle on. Either of them wins over an `ei_stb` or `iret_stb` in the same cycle.
- R6: `status_word` bit 14 of each core equals that core's global enable (1 = enabled), and its other 15 bits are 0.
- R7: `irq_req` of a core is 1 exactly when its global enable is 1 and at least one source has both its pending bit and its `irq_mask` bit set.
- R8: `irq_src` gives the lowest-numbered source whose pending and mask bits are both set while `irq_req` is 1. It is 0 while `irq_req` is 0.
- R9: The strobes, pulses and mask of core c only affect the outputs of core c. Core c uses bit slice [c*8 +: 8] of `irq_pulse` and `irq_mask`, slice [c*3 +: 3] of `svc_src` and `irq_src`, and slice [c*16 +: 16] of `status_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset, shared by both cores |
| irq_pulse | input | 16 | Request pulses, 8 sources per core |
| irq_mask | input | 16 | Per-source enables, 8 per core |
| ei_stb | input | 2 | Enable-interrupts strobe, one per core |
| di_stb | input | 2 | Disable-interrupts strobe, one per core |
| iret_stb | input | 2 | Interrupt-return strobe, one per core |
| svc_stb | input | 2 | Service-start strobe, one per core |
| svc_src | input | 6 | Source being serviced, 3 bits per core |
| irq_req | output | 2 | Interrupt request to each core |
| irq_src | output | 6 | Selected source number, 3 bits per core |
| status_word | output | 32 | Status word per core, global enable in bit 14 |

## Verification
The hardest case to reach from the ports is a service-start that clears a pending bit in the same cycle as a new pulse for the same source. The global enable falls in that cycle, so the kept bit only shows up after a later interrupt-return. The stimulus first builds that collision on purpose and follows it with an `iret_stb`. A long random phase then mixes colliding enable and disable strobes on both cores. A behavioural model is compared with every output on every cycle.

// File: rtl/irq_fe_pkg.sv
// Package: shared types for the interrupt front end.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_fe_pkg;

    // Action on the global enable flag in one cycle
    typedef enum logic [1:0] {
        GIE_KEEP = 2'd0,
        GIE_SET  = 2'd1,
        GIE_CLR  = 2'd2
    } gie_op_e;

    // Status word layout
    localparam int STAT_W  = 16;
    localparam int GIE_BIT = 14;

endpackage

// File: rtl/irq_pend_reg.sv
// Module: irq_pend_reg
// Holds one pending bit per source. A pulse sets its bit. A service
// acknowledge clears the bit of the named source, and a pulse in the
// same cycle wins over the clear.
// Assumes: pulses are one cycle wide and synchronous to clk.
module irq_pend_reg #(
    parameter int NUM_SRC = 8,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pulse_i,
    input  logic               ack_i,
    input  logic [IDW-1:0]     ack_src_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_vec;

    // Decode the acknowledged source into a clear vector
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            clr_vec[s] = ack_i && (ack_src_i == IDW'(s));
        end
    end

    // Update the pending bits: clear first, then set from pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | pulse_i;
        end
    end

    assign pend_o = pend_q;

    AST_PULSE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_i) |=> ((pend_q & $past(pulse_i)) == $past(pulse_i))); // R1

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !pulse_i[ack_src_i]) |=> !pend_q[$past(ack_src_i)]); // R2

    AST_UNACKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R1

endmodule

// File: rtl/irq_gie_ctl.sv
// Module: irq_gie_ctl
// Global interrupt enable flag of one core. Enable and return strobes
// set it; disable and service-start strobes clear it. Clearing wins.
// Assumes: strobes are one cycle wide, from the core's decoder.
module irq_gie_ctl
    import irq_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    input  logic iret_i,
    input  logic svc_i,
    output logic gie_o
);

    gie_op_e op;
    logic    gie_q;

    // Resolve the strobes into one action; clearing has priority
    always_comb begin
        if (di_i || svc_i) begin
            op = GIE_CLR;
        end else if (ei_i || iret_i) begin
            op = GIE_SET;
        end else begin
            op = GIE_KEEP;
        end
    end

    // Apply the action to the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else begin
            case (op)
                GIE_SET: gie_q <= 1'b1;
                GIE_CLR: gie_q <= 1'b0;
                default: gie_q <= gie_q;
            endcase
        end
    end

    assign gie_o = gie_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (di_i || svc_i) |=> !gie_q); // R5

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei_i || iret_i) && !di_i && !svc_i) |=> gie_q); // R4

    AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ei_i || di_i || iret_i || svc_i) |=> $stable(gie_q)); // R4

endmodule

// File: rtl/irq_prio_sel.sv
// Module: irq_prio_sel
// Finds the lowest-numbered candidate and gates the request with the
// global enable. Purely combinational.
// Assumes: cand_i is already pending AND mask.
module irq_prio_sel #(
    parameter int NUM_SRC = 8,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] cand_i,
    input  logic               gie_i,
    output logic               req_o,
    output logic [IDW-1:0]     src_o
);

    logic [IDW-1:0] low_idx;

    // Scan from the top down so the lowest index is kept last
    always_comb begin
        low_idx = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (cand_i[s]) begin
                low_idx = IDW'(s);
            end
        end
    end

    // Drive the request and source only when enabled
    always_comb begin
        req_o = gie_i && (|cand_i);
        src_o = req_o ? low_idx : '0;
    end

endmodule

// File: rtl/irq_core_fe.sv
// Module: irq_core_fe
// Interrupt front end of one core: pending register, global enable,
// priority selection and status word.
// Assumes: synchronous active-low reset shared with the other core.
module irq_core_fe
    import irq_fe_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pulse_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               iret_i,
    input  logic               svc_i,
    input  logic [IDW-1:0]     svc_src_i,
    output logic               req_o,
    output logic [IDW-1:0]     src_o,
    output logic [STAT_W-1:0]  status_o
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] cand;
    logic               gie;

    irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (pulse_i),
        .ack_i     (svc_i),
        .ack_src_i (svc_src_i),
        .pend_o    (pend)
    );

    irq_gie_ctl u_gie (
        .clk    (clk),
        .rst_n  (rst_n),
        .ei_i   (ei_i),
        .di_i   (di_i),
        .iret_i (iret_i),
        .svc_i  (svc_i),
        .gie_o  (gie)
    );

    // Qualify pending sources with the per-source enables
    assign cand = pend & mask_i;

    irq_prio_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .cand_i (cand),
        .gie_i  (gie),
        .req_o  (req_o),
        .src_o  (src_o)
    );

    // Place the global enable in its status bit
    always_comb begin
        status_o          = '0;
        status_o[GIE_BIT] = gie;
    end

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> gie); // R7

    AST_SRC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (cand[src_o] && ((cand & ~({NUM_SRC{1'b1}} << src_o)) == '0))); // R8

    AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> (src_o == '0)); // R8

    AST_AFTER_SVC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        svc_i |=> !req_o); // R5

endmodule

// File: rtl/irq_dual_fe.sv
// Module: irq_dual_fe
// Two independent per-core interrupt front ends that share a device
// reset. Per-core signals are packed side by side, core 0 in the low
// slice.
// Assumes: both cores run on the same clock.
module irq_dual_fe
    import irq_fe_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int NUM_SRC   = 8,
    localparam int IDW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES*NUM_SRC-1:0]  irq_pulse,
    input  logic [NUM_CORES*NUM_SRC-1:0]  irq_mask,
    input  logic [NUM_CORES-1:0]          ei_stb,
    input  logic [NUM_CORES-1:0]          di_stb,
    input  logic [NUM_CORES-1:0]          iret_stb,
    input  logic [NUM_CORES-1:0]          svc_stb,
    input  logic [NUM_CORES*IDW-1:0]      svc_src,
    output logic [NUM_CORES-1:0]          irq_req,
    output logic [NUM_CORES*IDW-1:0]      irq_src,
    output logic [NUM_CORES*STAT_W-1:0]   status_word
);

    // One front end per core, each on its own slice
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        irq_core_fe #(.NUM_SRC(NUM_SRC)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse_i   (irq_pulse[c*NUM_SRC +: NUM_SRC]),
            .mask_i    (irq_mask[c*NUM_SRC +: NUM_SRC]),
            .ei_i      (ei_stb[c]),
            .di_i      (di_stb[c]),
            .iret_i    (iret_stb[c]),
            .svc_i     (svc_stb[c]),
            .svc_src_i (svc_src[c*IDW +: IDW]),
            .req_o     (irq_req[c]),
            .src_o     (irq_src[c*IDW +: IDW]),
            .status_o  (status_word[c*STAT_W +: STAT_W])
        );

        AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_word[c*STAT_W +: STAT_W] & ~(STAT_W'(1) << GIE_BIT)) == '0)); // R6
    end

endmodule

// File: tb/irq_dual_fe_tb.sv
// Bench for irq_dual_fe: a behavioural model is stepped on each rising
// edge and every output is compared at each falling edge.
module irq_dual_fe_tb;

    localparam int NC = 2;
    localparam int NS = 8;
    localparam int IW = 3;
    localparam int SW = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC*NS-1:0] irq_pulse = '0;
    logic [NC*NS-1:0] irq_mask = '0;
    logic [NC-1:0]    ei_stb = '0, di_stb = '0, iret_stb = '0, svc_stb = '0;
    logic [NC*IW-1:0] svc_src = '0;
    logic [NC-1:0]    irq_req;
    logic [NC*IW-1:0] irq_src;
    logic [NC*SW-1:0] status_word;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bit m_pend[NC][NS];
    bit m_gie[NC];

    irq_dual_fe u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_mask(irq_mask),
        .ei_stb(ei_stb), .di_stb(di_stb), .iret_stb(iret_stb), .svc_stb(svc_stb),
        .svc_src(svc_src), .irq_req(irq_req), .irq_src(irq_src),
        .status_word(status_word)
    );

    always #5 clk = ~clk;

    // Reference model: stepped at each rising edge from the driven inputs
    always @(posedge clk) begin
        cycles++;
        for (int c = 0; c < NC; c++) begin
            if (!rst_n) begin
                m_gie[c] = 0;
                for (int s = 0; s < NS; s++) m_pend[c][s] = 0;
            end else begin
                for (int s = 0; s < NS; s++) begin
                    if (svc_stb[c] && (int'(svc_src[c*IW +: IW]) == s)) m_pend[c][s] = 0;
                    if (irq_pulse[c*NS + s]) m_pend[c][s] = 1;
                end
                if (di_stb[c] || svc_stb[c]) m_gie[c] = 0;
                else if (ei_stb[c] || iret_stb[c]) m_gie[c] = 1;
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp, input int c, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s core%0d %s got %0h exp %0h", tag, c, what, got, exp);
        end
    endtask

    // Compare all outputs of both cores with the model
    task automatic compare(input string tag);
        for (int c = 0; c < NC; c++) begin
            int e_src = 0;
            bit e_req = 0;
            for (int s = NS - 1; s >= 0; s--) begin
                if (m_pend[c][s] && irq_mask[c*NS + s]) begin
                    e_src = s;
                    e_req = 1;
                end
            end
            e_req = e_req && m_gie[c];
            if (!e_req) e_src = 0;
            check({tag, " R7"}, int'(irq_req[c]), int'(e_req), c, "irq_req");
            check({tag, " R8"}, int'(irq_src[c*IW +: IW]), e_src, c, "irq_src");
            check({tag, " R6"}, int'(status_word[c*SW +: SW]), int'(m_gie[c]) << 14, c, "status");
        end
    endtask

    // One clock: inputs already set; compare after the edge, then clear strobes
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        irq_pulse = '0;
        ei_stb = '0; di_stb = '0; iret_stb = '0; svc_stb = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        irq_pulse = '1; ei_stb = '1;            // ignored under reset
        step("R3 reset");
        step("R3 reset");
        check("R3", int'(irq_req), 0, 0, "irq_req both");
        check("R3", int'(status_word), 0, 0, "status both");
        rst_n = 1'b1;
        irq_mask = '1;

        irq_pulse[5] = 1'b1;                     // pending, gie still 0
        step("R1 R7 pulse no gie");
        check("R7", int'(irq_req[0]), 0, 0, "req with gie 0");
        ei_stb[0] = 1'b1;
        step("R4 ei");
        check("R4", int'(irq_src[IW-1:0]), 5, 0, "src after ei");
        check("R9", int'(status_word[SW +: SW]), 0, 1, "other core status");
        irq_pulse[2] = 1'b1;
        step("R8 lower source");
        check("R8", int'(irq_src[IW-1:0]), 2, 0, "lowest src");
        svc_stb[0] = 1'b1; svc_src[IW-1:0] = 3'd2;
        step("R5 svc");
        check("R5", int'(irq_req[0]), 0, 0, "req after svc");
        iret_stb[0] = 1'b1;
        step("R2 R4 iret");
        check("R2", int'(irq_src[IW-1:0]), 5, 0, "src 2 cleared");
        svc_stb[0] = 1'b1; svc_src[IW-1:0] = 3'd5; irq_pulse[5] = 1'b1;
        step("R2 collide");
        iret_stb[0] = 1'b1;
        step("R2 collide iret");
        check("R2", int'(irq_src[IW-1:0]), 5, 0, "pulse beats clear");
        ei_stb[0] = 1'b1; di_stb[0] = 1'b1;
        step("R5 ei di");
        check("R5", int'(status_word[SW-1:0]), 0, 0, "di wins");
        iret_stb[0] = 1'b1; svc_stb[0] = 1'b1; svc_src[IW-1:0] = 3'd7;
        step("R5 iret svc");
        check("R5", int'(status_word[SW-1:0]), 0, 0, "svc wins");
        irq_mask[5] = 1'b0; ei_stb[0] = 1'b1;
        step("R7 masked");
        check("R7", int'(irq_req[0]), 0, 0, "masked source");
        irq_mask[5] = 1'b1;
        step("R1 unmasked");
        check("R1", int'(irq_src[IW-1:0]), 5, 0, "still pending");
        ei_stb[1] = 1'b1;
        step("R9 core1 ei");
        check("R9", int'(irq_req[1]), 0, 1, "core1 no pending");

        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < NC*NS; b++) irq_pulse[b] = ($urandom_range(0, 9) == 0);
            for (int c = 0; c < NC; c++) begin
                ei_stb[c]   = ($urandom_range(0, 5) == 0);
                di_stb[c]   = ($urandom_range(0, 9) == 0);
                iret_stb[c] = ($urandom_range(0, 7) == 0);
                svc_stb[c]  = ($urandom_range(0, 6) == 0);
            end
            svc_src = NC*IW'($urandom);
            if ($urandom_range(0, 15) == 0) irq_mask = NC*NS'($urandom);
            if (i == 1500) rst_n = 1'b0;
            if (i == 1502) rst_n = 1'b1;
            step("R1 R2 R3 R4 R5 R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule